// File: doc/BRIEF.md
# Host bridge control register file

This block is the software-visible control register file of a PCIe host bridge. A byte-addressed request port with a 64-bit data path reaches a cache of 64-bit registers. Most registers are plain storage, but several carry side effects. Two ports AND or OR their value into a target register. A lock register is test-and-set on read. Some registers mask what is written to them. Some registers return a synthesized value instead of the stored one.

A four-byte configuration-data window forwards accesses to the configuration space of a downstream device. The window uses the bus number, device/function and register offset held in the configuration-address register. The forwarded request is a single-cycle port carrying device select, offset, size and data, with the answer returned combinationally in the same cycle. Window data is little-endian inside a big-endian region, so 2- and 4-byte values are byte-swapped in both directions.

Every request is answered on the clock edge that samples it. Read data and a valid flag appear on the registered outputs one cycle later, together with an access-error pulse, a changed strobe for downstream decode logic, and a sticky flag for accesses to undecoded offsets.

Top module: `hbr_ctl_regs`

## Requirements
- R1: An access outside the window (byte offsets 0x10 to 0x13) must be 8 bytes wide and 8-byte aligned. Inside the window only sizes 1, 2 and 4 are legal. Any other access is dropped if it is a write. If it is a read, it returns 0xFFFFFFFFFFFFFFFF. In both cases `acc_err_o` pulses for one cycle.
- R2: The configuration-address register is at offset 0x08. Bit 63 is the enable, bits 59:52 the bus, bits 51:44 the device/function, and bits 43:34 the upper register-offset bits. A window access at byte lane L (address bits 1:0) forwards offset {bits 43:34, L}, and the size in bytes, on the configuration port.
- R3: No configuration request is issued, writes have no effect, and reads return all ones when any of the following holds: the enable bit is clear, the target is absent, or the offset is at least the target's configuration size (256, or 4096 when `tgt_express_i` is set).
- R4: Window data of 2 or 4 bytes is byte-reversed on its way to and from the configuration port. 1-byte data passes unchanged. All data is right-justified.
- R5: A write to 0x48 ANDs into the fault accumulator at 0x40, and a write to 0x50 ORs into it. A write to 0x60 ANDs into the error mask at 0x58, and a write to 0x68 ORs into it. The four port offsets never store their value and read back zero.
- R6: A read of the lock register at 0x28 returns its previous contents and sets bit 63 of it.
- R7: A write to 0x18 stores only bits 63:50. A write to 0x70 always stores zero.
- R8: On a write to the quiesce register at 0x20, bit 62 set clears the register. Otherwise only bit 63 of the value is kept.
- R9: Offset 0x00 reads 0x000000A300000005. Offset 0x30 reads bit 63 only. Offset 0x38 reads bits 63 and 60 when `link_dev_i` is high and zero otherwise.
- R10: `changed_o` pulses for one cycle after any access that gives a stored register a new value. This includes AND/OR targets and the lock set by a read.
- R11: Offsets 0x78 and above are plain storage. An aligned 8-byte access to them sets `unimp_o`, which stays set until reset.
- R12: `rvalid_o` and `rdata_o` follow a read request by exactly one cycle. After reset every register holds zero and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Single-cycle access request |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | AW | Byte offset |
| size_i | input | 4 | Access size in bytes (1, 2, 4, 8) |
| wdata_i | input | 64 | Write data, right-justified |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 64 | Read data |
| acc_err_o | output | 1 | Illegal size or alignment, one-cycle pulse |
| changed_o | output | 1 | A stored register changed value |
| unimp_o | output | 1 | Sticky undecoded-offset flag |
| link_dev_i | input | 1 | A device is attached on bus 1 |
| cfg_req_o | output | 1 | Configuration request |
| cfg_we_o | output | 1 | Configuration write |
| cfg_bus_o | output | 8 | Target bus number |
| cfg_devfn_o | output | 8 | Target device/function |
| cfg_off_o | output | 12 | Configuration register offset |
| cfg_size_o | output | 3 | Configuration access size in bytes |
| cfg_wdata_o | output | 32 | Configuration write data, little-endian |
| cfg_rdata_i | input | 32 | Configuration read data, little-endian |
| tgt_present_i | input | 1 | Addressed target exists |
| tgt_express_i | input | 1 | Addressed target has a 4096-byte space |

## Verification
The assertions assume that a request lasts one cycle. They also assume that the target inputs (`tgt_present_i`, `tgt_express_i`, `cfg_rdata_i`) answer combinationally from the bus, device and offset on the configuration port within that cycle. The bench's target model meets this by decoding the port outputs directly. The bench keeps window accesses with lane plus size within four bytes, so every forwarded byte lies inside the addressed word. It also drives all inputs to known values throughout reset.

// File: rtl/hbr_pkg.sv
package hbr_pkg;
  // register indices (byte offset / 8); the decode depends on these
  localparam int IX_VER    = 0;
  localparam int IX_CFGA   = 1;
  localparam int IX_CFGD   = 2;
  localparam int IX_UPPER  = 3;
  localparam int IX_QUI    = 4;
  localparam int IX_LOCK   = 5;
  localparam int IX_SYNC   = 6;
  localparam int IX_LINK   = 7;
  localparam int IX_FACC   = 8;
  localparam int IX_FAND   = 9;
  localparam int IX_FOR    = 10;
  localparam int IX_EMSK   = 11;
  localparam int IX_EAND   = 12;
  localparam int IX_EOR    = 13;
  localparam int IX_WONCE  = 14;
  localparam int IX_LAST   = 14;

  localparam logic [63:0] VERSION_VAL = 64'h0000_00A3_0000_0005;
  localparam logic [63:0] UPPER_MASK  = 64'hFFFC_0000_0000_0000;
  localparam logic [63:0] QUI_KEEP    = 64'h8000_0000_0000_0000;
  localparam int          QUI_AUTO    = 62;
  localparam logic [63:0] LOCK_BIT    = 64'h8000_0000_0000_0000;
  localparam logic [63:0] SYNC_DONE   = 64'h8000_0000_0000_0000;
  localparam logic [63:0] LINK_UP     = 64'h9000_0000_0000_0000;

  // reverse the significant bytes of a right-justified value
  function automatic logic [31:0] lane_swap(input logic [31:0] v, input logic [3:0] sz);
    case (sz)
      4'd2:    return {16'h0, v[7:0], v[15:8]};
      4'd4:    return {v[7:0], v[15:8], v[23:16], v[31:24]};
      default: return {24'h0, v[7:0]};
    endcase
  endfunction

  function automatic logic [12:0] cfg_limit(input logic express);
    return express ? 13'd4096 : 13'd256;
  endfunction
endpackage

// File: rtl/hbr_acc_chk.sv
module hbr_acc_chk #(
  parameter int AW = 8
) (
  input  logic          req,
  input  logic [AW-1:0] addr,
  input  logic [3:0]    sz,
  output logic          win_go,
  output logic          st_acc,
  output logic          bad
);
  import hbr_pkg::*;
  localparam logic [AW-3:0] WIN_W = (AW-2)'(IX_CFGD * 2);

  logic in_win, win_ok, word_ok;
  always_comb begin
    in_win  = (addr[AW-1:2] == WIN_W);
    win_ok  = (sz == 4'd1) || (sz == 4'd2) || (sz == 4'd4);
    word_ok = (addr[2:0] == 3'd0) && (sz == 4'd8);
    win_go  = req && in_win && win_ok;
    st_acc  = req && !in_win && word_ok;
    bad     = req && (in_win ? !win_ok : !word_ok);
  end
endmodule

// File: rtl/hbr_cfg_port.sv
module hbr_cfg_port (
  input  logic        go,
  input  logic        we,
  input  logic [1:0]  lane,
  input  logic [3:0]  sz,
  input  logic [31:0] wdata,
  input  logic [63:0] cfg_word,
  input  logic        tgt_present,
  input  logic        tgt_express,
  input  logic [31:0] cfg_rdata,
  output logic        cfg_req,
  output logic        cfg_we,
  output logic [7:0]  cfg_bus,
  output logic [7:0]  cfg_devfn,
  output logic [11:0] cfg_off,
  output logic [2:0]  cfg_size,
  output logic [31:0] cfg_wdata,
  output logic [63:0] rd_res
);
  import hbr_pkg::*;

  logic hit;
  always_comb begin
    cfg_bus   = cfg_word[59:52];
    cfg_devfn = cfg_word[51:44];
    cfg_off   = {cfg_word[43:34], lane};
    hit       = go && cfg_word[63] && tgt_present &&
                ({1'b0, cfg_off} < cfg_limit(tgt_express));
    cfg_req   = hit;
    cfg_we    = hit && we;
    cfg_size  = sz[2:0];
    cfg_wdata = lane_swap(wdata, sz);
    rd_res    = hit ? {32'h0, lane_swap(cfg_rdata, sz)} : '1;
  end
endmodule

// File: rtl/hbr_reg_store.sv
module hbr_reg_store #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic          we,
  input  logic [AW-4:0] idx,
  input  logic [63:0]   wdata,
  input  logic          link_up,
  output logic [63:0]   rd_val,
  output logic          chg_now,
  output logic          unimp_hit,
  output logic [63:0]   cfg_word
);
  import hbr_pkg::*;
  localparam int IW   = AW - 3;
  localparam int NREG = 1 << IW;

  logic [63:0]   regs [NREG];
  logic [IW-1:0] tgt;
  logic [63:0]   nv;
  logic          wr_en;

  always_comb begin
    tgt   = idx;
    nv    = wdata;
    wr_en = acc && we;
    if (acc && we) begin
      case (idx)
        IW'(IX_UPPER): nv = wdata & UPPER_MASK;
        IW'(IX_QUI):   nv = wdata[QUI_AUTO] ? '0 : (wdata & QUI_KEEP);
        IW'(IX_FAND):  begin tgt = IW'(IX_FACC); nv = regs[IX_FACC] & wdata; end
        IW'(IX_FOR):   begin tgt = IW'(IX_FACC); nv = regs[IX_FACC] | wdata; end
        IW'(IX_EAND):  begin tgt = IW'(IX_EMSK); nv = regs[IX_EMSK] & wdata; end
        IW'(IX_EOR):   begin tgt = IW'(IX_EMSK); nv = regs[IX_EMSK] | wdata; end
        IW'(IX_WONCE): nv = '0;
        default:       nv = wdata;
      endcase
    end else if (acc && idx == IW'(IX_LOCK)) begin
      wr_en = 1'b1;
      nv    = regs[IX_LOCK] | LOCK_BIT;
    end
    chg_now   = wr_en && (nv != regs[tgt]);
    unimp_hit = acc && (idx > IW'(IX_LAST));
    cfg_word  = regs[IX_CFGA];
    case (idx)
      IW'(IX_VER):  rd_val = VERSION_VAL;
      IW'(IX_SYNC): rd_val = SYNC_DONE;
      IW'(IX_LINK): rd_val = link_up ? LINK_UP : '0;
      default:      rd_val = regs[idx];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_en) begin
      regs[tgt] <= nv;
    end
  end

  // named events for the checks below
  logic        lock_rd_ev, wonce_wr_ev, upper_wr_ev;
  logic        lock_state;
  logic [63:0] wonce_word;
  logic [49:0] upper_low;
  assign lock_rd_ev  = acc && !we && idx == IW'(IX_LOCK);
  assign wonce_wr_ev = acc && we && idx == IW'(IX_WONCE);
  assign upper_wr_ev = acc && we && idx == IW'(IX_UPPER);
  assign lock_state  = regs[IX_LOCK][63];
  assign wonce_word  = regs[IX_WONCE];
  assign upper_low   = regs[IX_UPPER][49:0];

  p_lock_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lock_rd_ev |=> lock_state);
  p_wonce_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wonce_wr_ev |=> (wonce_word == 64'h0));
  p_upper_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    upper_wr_ev |=> (upper_low == 50'h0));
endmodule

// File: rtl/hbr_ctl_regs.sv
module hbr_ctl_regs #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [3:0]    size_i,
  input  logic [63:0]   wdata_i,
  output logic          rvalid_o,
  output logic [63:0]   rdata_o,
  output logic          acc_err_o,
  output logic          changed_o,
  output logic          unimp_o,
  input  logic          link_dev_i,
  output logic          cfg_req_o,
  output logic          cfg_we_o,
  output logic [7:0]    cfg_bus_o,
  output logic [7:0]    cfg_devfn_o,
  output logic [11:0]   cfg_off_o,
  output logic [2:0]    cfg_size_o,
  output logic [31:0]   cfg_wdata_o,
  input  logic [31:0]   cfg_rdata_i,
  input  logic          tgt_present_i,
  input  logic          tgt_express_i
);
  logic        win_go, st_acc, bad;
  logic [63:0] st_rd, cfg_res, cfg_word;
  logic        chg_now, unimp_hit;

  hbr_acc_chk #(.AW(AW)) u_chk (
    .req(req_i), .addr(addr_i), .sz(size_i),
    .win_go(win_go), .st_acc(st_acc), .bad(bad));

  hbr_reg_store #(.AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .acc(st_acc), .we(we_i), .idx(addr_i[AW-1:3]),
    .wdata(wdata_i), .link_up(link_dev_i), .rd_val(st_rd), .chg_now(chg_now),
    .unimp_hit(unimp_hit), .cfg_word(cfg_word));

  hbr_cfg_port u_cfg (
    .go(win_go), .we(we_i), .lane(addr_i[1:0]), .sz(size_i),
    .wdata(wdata_i[31:0]), .cfg_word(cfg_word), .tgt_present(tgt_present_i),
    .tgt_express(tgt_express_i), .cfg_rdata(cfg_rdata_i),
    .cfg_req(cfg_req_o), .cfg_we(cfg_we_o), .cfg_bus(cfg_bus_o),
    .cfg_devfn(cfg_devfn_o), .cfg_off(cfg_off_o), .cfg_size(cfg_size_o),
    .cfg_wdata(cfg_wdata_o), .rd_res(cfg_res));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_o  <= 1'b0;
      rdata_o   <= '0;
      acc_err_o <= 1'b0;
      changed_o <= 1'b0;
      unimp_o   <= 1'b0;
    end else begin
      rvalid_o  <= req_i && !we_i;
      if (req_i && !we_i)
        rdata_o <= bad ? '1 : (win_go ? cfg_res : st_rd);
      else
        rdata_o <= '0;
      acc_err_o <= bad;
      changed_o <= chg_now;
      unimp_o   <= unimp_o | unimp_hit;
    end
  end

  p_bad_read_ones_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bad && !we_i) |=> (acc_err_o && rvalid_o && rdata_o == '1));
  p_cfg_only_on_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_o |-> (req_i && !acc_err_o || req_i));
  p_chg_after_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    changed_o |-> $past(req_i));
  p_unimp_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(unimp_o));
  p_rvalid_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !we_i) |=> rvalid_o);
endmodule

// File: tb/hbr_ctl_regs_tb.sv
module hbr_ctl_regs_tb;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0;
  logic [7:0] addr = 0;
  logic [3:0] sz = 0;
  logic [63:0] wdata = 0;
  logic rvalid, acc_err, changed, unimp;
  logic [63:0] rdata;
  logic link_dev = 0;
  logic cfg_req, cfg_we;
  logic [7:0] cfg_bus, cfg_devfn;
  logic [11:0] cfg_off;
  logic [2:0] cfg_size;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic tgt_present, tgt_express = 0;

  always #(PERIOD/2) clk = ~clk;

  hbr_ctl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .size_i(sz),
    .wdata_i(wdata), .rvalid_o(rvalid), .rdata_o(rdata), .acc_err_o(acc_err),
    .changed_o(changed), .unimp_o(unimp), .link_dev_i(link_dev),
    .cfg_req_o(cfg_req), .cfg_we_o(cfg_we), .cfg_bus_o(cfg_bus),
    .cfg_devfn_o(cfg_devfn), .cfg_off_o(cfg_off), .cfg_size_o(cfg_size),
    .cfg_wdata_o(cfg_wdata), .cfg_rdata_i(cfg_rdata),
    .tgt_present_i(tgt_present), .tgt_express_i(tgt_express));

  // target model: one device at bus 1, devfn 0x08, little-endian space
  logic [7:0] cs [4096];
  logic [7:0]  cap_bus, cap_devfn;
  logic [11:0] cap_off;
  logic [2:0]  cap_size;
  assign tgt_present = (cfg_bus == 8'd1) && (cfg_devfn == 8'h08);
  assign cfg_rdata = {cs[cfg_off + 12'd3], cs[cfg_off + 12'd2],
                      cs[cfg_off + 12'd1], cs[cfg_off]};
  always @(posedge clk) if (cfg_req && cfg_we) begin
    for (int k = 0; k < int'(cfg_size); k++)
      cs[cfg_off + 12'(k)] <= cfg_wdata[8*k +: 8];
    cap_bus <= cfg_bus; cap_devfn <= cfg_devfn;
    cap_off <= cfg_off; cap_size <= cfg_size;
  end

  // reference model
  logic [63:0] m [32];
  int total = 0, bad = 0;
  logic pend_rv = 0, pend_err = 0, pend_chg = 0, pend_un = 0;
  logic [63:0] pend_rd = 0;
  string pend_tag = "", exp_tag = "";
  logic exp_rv = 0, exp_err = 0, exp_chg = 0, exp_un = 0;
  logic [63:0] exp_rd = 0;
  logic mon_on = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (mon_on) begin
    chk({exp_tag, " rvalid (R12)"}, 64'(rvalid), 64'(exp_rv));
    chk({exp_tag, " acc_err (R1)"}, 64'(acc_err), 64'(exp_err));
    chk({exp_tag, " changed (R10)"}, 64'(changed), 64'(exp_chg));
    chk({exp_tag, " unimp (R11)"}, 64'(unimp), 64'(exp_un));
    if (exp_rv) chk({exp_tag, " rdata"}, rdata, exp_rd);
  end

  task automatic step();
    @(posedge clk); #1;
    exp_rv = pend_rv; exp_err = pend_err; exp_chg = pend_chg;
    exp_un = exp_un | pend_un; exp_rd = pend_rd; exp_tag = pend_tag;
    pend_rv = 0; pend_err = 0; pend_chg = 0; pend_un = 0; pend_rd = 0;
    req = 0; we = 0;
  endtask

  task automatic acc(input logic w, input logic [7:0] a, input logic [3:0] s,
                     input logic [63:0] d, input string tag);
    logic win, okw, okd, hit;
    int ix, off;
    logic [63:0] nv, cw, rv;
    step();
    req = 1; we = w; addr = a; sz = s; wdata = d;
    pend_tag = tag; pend_rv = !w;
    win = (a >= 8'h10 && a <= 8'h13);
    okw = (s == 1 || s == 2 || s == 4);
    okd = (a[2:0] == 0) && (s == 8);
    if (win ? !okw : !okd) begin
      pend_err = 1; pend_rd = '1;
    end else if (win) begin
      cw = m[1];
      off = int'(cw[43:34]) * 4 + int'(a[1:0]);
      hit = cw[63] && cw[59:52] == 1 && cw[51:44] == 8'h08 &&
            off < (tgt_express ? 4096 : 256);
      rv = 0;
      for (int i = 0; i < int'(s); i++) rv = (rv << 8) | 64'(cs[off + i]);
      pend_rd = hit ? rv : '1;
    end else begin
      ix = int'(a[7:3]);
      if (ix > 14) pend_un = 1;
      case (ix)
        0: rv = 64'h0000_00A3_0000_0005;
        6: rv = 64'h8000_0000_0000_0000;
        7: rv = link_dev ? 64'h9000_0000_0000_0000 : 0;
        default: rv = m[ix];
      endcase
      pend_rd = rv;
      if (w) begin
        nv = d;
        case (ix)
          3:  nv = d & 64'hFFFC_0000_0000_0000;
          4:  nv = d[62] ? 0 : (d & 64'h8000_0000_0000_0000);
          9:  begin nv = m[8] & d; ix = 8; end
          10: begin nv = m[8] | d; ix = 8; end
          12: begin nv = m[11] & d; ix = 11; end
          13: begin nv = m[11] | d; ix = 11; end
          14: nv = 0;
          default: ;
        endcase
        pend_chg = (nv != m[ix]); m[ix] = nv;
      end else if (ix == 5) begin
        nv = m[5] | 64'h8000_0000_0000_0000;
        pend_chg = (nv != m[5]); m[5] = nv;
      end
    end
  endtask

  function automatic logic [63:0] cfga(input logic en, input int bus, input int df, input int off);
    return {en, 3'b0, 8'(bus), 8'(df), 12'(off), 32'h0};
  endfunction

  initial begin
    #(PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) m[i] = 0;
    for (int i = 0; i < 4096; i++) cs[i] = 8'(i * 7 + 3);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("reset rvalid R12", 64'(rvalid), 0);
    chk("reset unimp R12", 64'(unimp), 0);
    chk("reset changed R12", 64'(changed), 0);
    mon_on = 1;
    // R9 synthesized reads
    acc(0, 8'h00, 8, 0, "version R9");
    acc(0, 8'h30, 8, 0, "sync R9");
    acc(0, 8'h38, 8, 0, "link down R9");
    step(); link_dev = 1;
    acc(0, 8'h38, 8, 0, "link up R9");
    // R1 bad accesses
    acc(1, 8'h18, 4, 64'hFFFF, "short write R1");
    acc(0, 8'h1C, 8, 0, "misaligned read R1");
    acc(0, 8'h18, 8, 0, "dropped write readback R1");
    acc(0, 8'h10, 8, 0, "window size 8 R1");
    // R7 masks
    acc(1, 8'h18, 8, '1, "upper mask R7");
    acc(0, 8'h18, 8, 0, "upper readback R7");
    acc(1, 8'h70, 8, 64'h1234, "wonce R7");
    acc(0, 8'h70, 8, 0, "wonce readback R7");
    // R8 quiesce
    acc(1, 8'h20, 8, 64'h8000_0000_0000_00FF, "quiesce keep R8");
    acc(0, 8'h20, 8, 0, "quiesce readback R8");
    acc(1, 8'h20, 8, 64'hC000_0000_0000_0000, "quiesce autoreset R8");
    acc(0, 8'h20, 8, 0, "quiesce cleared R8");
    // R5 AND/OR ports
    acc(1, 8'h40, 8, 64'hF0F0, "facc load R5");
    acc(1, 8'h48, 8, 64'hFF00, "facc and R5");
    acc(0, 8'h40, 8, 0, "facc after and R5");
    acc(1, 8'h50, 8, 64'h000F, "facc or R5");
    acc(0, 8'h40, 8, 0, "facc after or R5");
    acc(0, 8'h48, 8, 0, "and port reads zero R5");
    acc(1, 8'h68, 8, 64'hAA, "emask or R5");
    acc(1, 8'h60, 8, 64'h0F, "emask and R5");
    acc(0, 8'h58, 8, 0, "emask readback R5");
    acc(0, 8'h60, 8, 0, "emask and port zero R5");
    // R6 lock
    acc(0, 8'h28, 8, 0, "lock first read R6");
    acc(0, 8'h28, 8, 0, "lock second read R6");
    acc(1, 8'h28, 8, 0, "lock release R6");
    acc(0, 8'h28, 8, 0, "lock reacquire R6");
    // R10 same value rewrite gives no strobe
    acc(1, 8'h40, 8, 64'hF00F, "same value R10");
    // R11 unknown offsets
    acc(1, 8'h80, 8, 64'hDEAD_BEEF, "unknown write R11");
    acc(0, 8'h80, 8, 0, "unknown readback R11");
    // R2/R4 config window
    acc(1, 8'h08, 8, cfga(1, 1, 8'h08, 12'h010), "cfg addr R2");
    acc(1, 8'h10, 4, 64'h1122_3344, "cfg write 4 R4");
    step();
    chk("cfg bus R2", 64'(cap_bus), 1);
    chk("cfg devfn R2", 64'(cap_devfn), 64'h08);
    chk("cfg off R2", 64'(cap_off), 64'h010);
    chk("cfg size R2", 64'(cap_size), 4);
    acc(0, 8'h10, 4, 0, "cfg read 4 R4");
    acc(0, 8'h12, 2, 0, "cfg read 2 lane R2");
    acc(0, 8'h13, 1, 0, "cfg read 1 R4");
    acc(1, 8'h11, 2, 64'hA1B2, "cfg write 2 R4");
    step();
    chk("cfg lane off R2", 64'(cap_off), 64'h011);
    acc(0, 8'h10, 4, 0, "cfg read after 2 R4");
    // R3 gating
    acc(1, 8'h08, 8, cfga(1, 1, 8'h08, 12'h100), "cfg addr high R3");
    acc(0, 8'h10, 4, 0, "conv out of range R3");
    acc(1, 8'h10, 4, 64'h5555_5555, "conv write ignored R3");
    step(); tgt_express = 1;
    acc(0, 8'h10, 4, 0, "express in range R3");
    acc(1, 8'h08, 8, cfga(0, 1, 8'h08, 12'h010), "cfg disabled R3");
    acc(0, 8'h10, 4, 0, "disabled read R3");
    acc(1, 8'h08, 8, cfga(1, 2, 8'h08, 12'h010), "cfg absent R3");
    acc(0, 8'h10, 4, 0, "absent read R3");
    acc(1, 8'h10, 1, 64'h77, "absent write ignored R3");
    acc(1, 8'h08, 8, cfga(1, 1, 8'h08, 12'h010), "cfg restore R3");
    acc(0, 8'h10, 4, 0, "no write leaked R3");
    step(); step();
    mon_on = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule